// File: doc/BRIEF.md
# Trigger Event Packet Formatter

This block turns each accepted trigger into a short fixed-format report for the readout network. When the accept strobe arrives and packets are enabled, the block captures the current trigger state into registers in one cycle. The state covers the time base value, the accepted, input and pulser trigger counts, the discriminator OR and coincidence flags, the multiplicity, and the masked NIM and eSATA input bits. It then sends a ten-word packet of 32-bit words on a valid/ready stream.

The packet opens with a running packet number. Tagged header and footer words, each carrying the low 28 bits of the accepted-trigger count, frame the payload so a receiver can spot a torn or misaligned packet. The block sends one packet at a time. An accept that arrives while a packet is still going out is not queued. It is dropped, and a saturating counter records the drop. The network stack downstream and the trigger decision logic upstream lie outside this block.

Top module: `trig_pkt_fmt`

## Requirements
- R1: After reset `out_valid` is low and `drop_cnt` is zero. The first packet sent carries packet number 0.
- R2: When `accept` is high, `pkt_en` is high and no packet is in flight at a clock edge, `out_valid` rises after that edge and word 0 is presented.
- R3: Word 0 is the packet number. It is zero after reset and increases by one each time a packet completes, that is, when its word 9 is accepted by the consumer.
- R4: Word 1 is the header. Bits 31:28 hold 0x8 and bits 27:0 hold bits 27:0 of `cnt_accepted`.
- R5: Words 2, 3, 4 and 5 are `timestamp`, `cnt_accepted`, `cnt_input` and `cnt_pulser`, in that order.
- R6: Word 6 is the trigger bitmap. Bit 0 is `adc16_or`, bit 1 is `adc32_or`, bit 2 is `adc_any_or`, bit 3 is `ext_or`, bit 4 is `coinc_top`, bit 5 is `coinc_bot` and bit 6 is `coinc_all`. Bit 7 is 0, bits 23:8 are `coinc_reg` and bits 31:24 are `mult_cnt`.
- R7: Word 7 is `nim_bits` and word 8 is `esata_bits`. Each holds 32 bits, two per ADC module.
- R8: Word 9 is the footer. Bits 31:28 hold 0x9 and bits 27:0 hold the same 27:0 bits of `cnt_accepted` as the header.
- R9: While `pkt_en` is low, an `accept` on an idle block starts no packet and leaves `drop_cnt` unchanged.
- R10: Every payload word reflects the inputs at the accepting edge. Later changes to the inputs do not alter a packet in flight.
- R11: The word index advances only on a cycle with `out_valid` and `out_ready` both high. While the consumer stalls, `out_data` and `out_last` hold their values. `out_last` is high on word 9 and on no other word.
- R12: An `accept` on a cycle with `out_valid` high is dropped and increments `drop_cnt` by one. This includes the cycle in which word 9 completes. The counter saturates at its all-ones value.
- R13: Lowering `pkt_en` while a packet is in flight does not shorten the packet. All ten words are still sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_en | input | 1 | Packet generation enable |
| accept | input | 1 | Accepted-trigger strobe, one cycle |
| timestamp | input | 32 | Trigger time from the 62.5 MHz time base |
| cnt_accepted | input | 32 | Accepted-trigger count |
| cnt_input | input | 32 | Input-trigger count |
| cnt_pulser | input | 32 | Pulser-trigger count |
| adc16_or | input | 1 | OR of the 16-channel ADC discriminators |
| adc32_or | input | 1 | OR of the 32-channel ADC discriminators |
| adc_any_or | input | 1 | Combined OR of all ADC discriminators |
| ext_or | input | 1 | OR of the NIM and eSATA inputs |
| coinc_top | input | 1 | Top-half ADC16 coincidence |
| coinc_bot | input | 1 | Bottom-half ADC16 coincidence |
| coinc_all | input | 1 | Overall ADC16 coincidence |
| coinc_reg | input | 16 | Registered coincidence pattern |
| mult_cnt | input | 8 | Low 8 bits of multiplicity |
| nim_bits | input | 32 | Masked NIM bits, two per ADC |
| esata_bits | input | 32 | Masked eSATA bits, two per ADC |
| out_data | output | 32 | Packet word |
| out_valid | output | 1 | Word valid |
| out_ready | input | 1 | Consumer ready |
| out_last | output | 1 | High on the final word of a packet |
| drop_cnt | output | OVF_W | Saturating count of dropped accepts |

## Verification
The hardest case to reach is an accept that lands on the very cycle in which the footer is handed over. The block is busy for exactly that cycle, so the accept must be dropped and counted. An accept one cycle later must start a fresh packet. The bench reaches this by counting nine handshakes after a start with ready held high, raising accept on the tenth, and raising it again on the next cycle. A stalled packet with a stream of dropped accepts drives the drop counter into saturation. The bench uses a narrow counter width so saturation takes only a few cycles. The payload inputs change randomly on every cycle, which tests capture isolation on every packet.

// File: rtl/trig_pkt_pkg.sv
// Shared constants and types for the trigger packet formatter.
package trig_pkt_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned NUM_WORDS = 10;
    localparam int unsigned IDX_W     = $clog2(NUM_WORDS);
    localparam int unsigned TAG_W     = 4;
    localparam int unsigned LOW_W     = WORD_W - TAG_W;

    localparam logic [TAG_W-1:0] TAG_HEAD = 4'h8;
    localparam logic [TAG_W-1:0] TAG_FOOT = 4'h9;

    typedef logic [IDX_W-1:0]  widx_t;
    typedef logic [WORD_W-1:0] word_t;

    // Word positions; the order is the packet format.
    localparam widx_t W_PKTNUM = widx_t'(0);
    localparam widx_t W_HEAD   = widx_t'(1);
    localparam widx_t W_TS     = widx_t'(2);
    localparam widx_t W_ACC    = widx_t'(3);
    localparam widx_t W_IN     = widx_t'(4);
    localparam widx_t W_PULS   = widx_t'(5);
    localparam widx_t W_BITMAP = widx_t'(6);
    localparam widx_t W_NIM    = widx_t'(7);
    localparam widx_t W_ESATA  = widx_t'(8);
    localparam widx_t W_FOOT   = widx_t'(NUM_WORDS - 1);

    // Registered trigger state held for the packet in flight.
    typedef struct packed {
        word_t ts;
        word_t acc;
        word_t inp;
        word_t puls;
        word_t bitmap;
        word_t nim;
        word_t esata;
    } snap_t;
endpackage

// File: rtl/trig_pkt_snap.sv
// Snapshot register: packs the trigger bitmap and latches all payload
// fields when the sequencer grants a capture.
// Assumes: cap is a single-cycle strobe issued only while idle.
module trig_pkt_snap
    import trig_pkt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cap,
    input  word_t       timestamp,
    input  word_t       cnt_accepted,
    input  word_t       cnt_input,
    input  word_t       cnt_pulser,
    input  logic        adc16_or,
    input  logic        adc32_or,
    input  logic        adc_any_or,
    input  logic        ext_or,
    input  logic        coinc_top,
    input  logic        coinc_bot,
    input  logic        coinc_all,
    input  logic [15:0] coinc_reg,
    input  logic [7:0]  mult_cnt,
    input  word_t       nim_bits,
    input  word_t       esata_bits,
    output snap_t       snap
);
    word_t bitmap_now;

    // Pack the discriminator and coincidence flags into the bitmap word.
    always_comb begin
        bitmap_now = {mult_cnt, coinc_reg, 1'b0, coinc_all, coinc_bot,
                      coinc_top, ext_or, adc_any_or, adc32_or, adc16_or};
    end

    // Latch every payload field on a granted capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap <= '0;
        end else if (cap) begin
            snap.ts     <= timestamp;
            snap.acc    <= cnt_accepted;
            snap.inp    <= cnt_input;
            snap.puls   <= cnt_pulser;
            snap.bitmap <= bitmap_now;
            snap.nim    <= nim_bits;
            snap.esata  <= esata_bits;
        end
    end
endmodule

// File: rtl/trig_pkt_seq.sv
// Packet sequencer: decides when a packet starts, steps the word index
// on each handshake, keeps the packet number and the saturating drop count.
// Assumes: out_ready may change on any cycle; accept is a one-cycle strobe.
module trig_pkt_seq
    import trig_pkt_pkg::*;
#(
    parameter int unsigned OVF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_en,
    input  logic             accept,
    input  logic             out_ready,
    output logic             busy,
    output widx_t            idx,
    output logic             cap,
    output logic             last,
    output word_t            pkt_num,
    output logic [OVF_W-1:0] drop_cnt
);
    localparam logic [OVF_W-1:0] DROP_MAX = '1;

    logic fire;

    // Handshake, capture grant and last-word flag.
    always_comb begin
        fire = busy && out_ready;
        cap  = !busy && accept && pkt_en;
        last = busy && (idx == W_FOOT);
    end

    // Busy flag, word index and packet number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            idx     <= '0;
            pkt_num <= '0;
        end else if (busy) begin
            if (fire) begin
                if (idx == W_FOOT) begin
                    busy    <= 1'b0;
                    idx     <= '0;
                    pkt_num <= pkt_num + 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end else if (cap) begin
            busy <= 1'b1;
            idx  <= '0;
        end
    end

    // Count accepts that arrive while a packet is in flight, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_cnt <= '0;
        end else if (busy && accept && (drop_cnt != DROP_MAX)) begin
            drop_cnt <= drop_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/trig_pkt_mux.sv
// Word selector: builds the outgoing word for the current index from the
// snapshot, the packet number and the header and footer tags.
// Assumes: idx stays below NUM_WORDS.
module trig_pkt_mux
    import trig_pkt_pkg::*;
(
    input  widx_t idx,
    input  word_t pkt_num,
    input  snap_t snap,
    output word_t word
);
    // Pick the word for the current position in the packet.
    always_comb begin
        case (idx)
            W_PKTNUM: word = pkt_num;
            W_HEAD:   word = {TAG_HEAD, snap.acc[LOW_W-1:0]};
            W_TS:     word = snap.ts;
            W_ACC:    word = snap.acc;
            W_IN:     word = snap.inp;
            W_PULS:   word = snap.puls;
            W_BITMAP: word = snap.bitmap;
            W_NIM:    word = snap.nim;
            W_ESATA:  word = snap.esata;
            W_FOOT:   word = {TAG_FOOT, snap.acc[LOW_W-1:0]};
            default:  word = '0;
        endcase
    end
endmodule

// File: rtl/trig_pkt_fmt.sv
// Trigger event packet formatter top: snapshot on accept, then a ten-word
// packet on a valid/ready stream. Assumes a single clock domain.
module trig_pkt_fmt
    import trig_pkt_pkg::*;
#(
    parameter int unsigned OVF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_en,
    input  logic             accept,
    input  logic [31:0]      timestamp,
    input  logic [31:0]      cnt_accepted,
    input  logic [31:0]      cnt_input,
    input  logic [31:0]      cnt_pulser,
    input  logic             adc16_or,
    input  logic             adc32_or,
    input  logic             adc_any_or,
    input  logic             ext_or,
    input  logic             coinc_top,
    input  logic             coinc_bot,
    input  logic             coinc_all,
    input  logic [15:0]      coinc_reg,
    input  logic [7:0]       mult_cnt,
    input  logic [31:0]      nim_bits,
    input  logic [31:0]      esata_bits,
    output logic [31:0]      out_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_last,
    output logic [OVF_W-1:0] drop_cnt
);
    logic  busy, cap, last;
    widx_t idx;
    word_t pkt_num;
    snap_t snap;

    trig_pkt_seq #(.OVF_W(OVF_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .pkt_en(pkt_en), .accept(accept),
        .out_ready(out_ready), .busy(busy), .idx(idx), .cap(cap),
        .last(last), .pkt_num(pkt_num), .drop_cnt(drop_cnt)
    );

    trig_pkt_snap u_snap (
        .clk(clk), .rst_n(rst_n), .cap(cap),
        .timestamp(timestamp), .cnt_accepted(cnt_accepted),
        .cnt_input(cnt_input), .cnt_pulser(cnt_pulser),
        .adc16_or(adc16_or), .adc32_or(adc32_or), .adc_any_or(adc_any_or),
        .ext_or(ext_or), .coinc_top(coinc_top), .coinc_bot(coinc_bot),
        .coinc_all(coinc_all), .coinc_reg(coinc_reg), .mult_cnt(mult_cnt),
        .nim_bits(nim_bits), .esata_bits(esata_bits), .snap(snap)
    );

    trig_pkt_mux u_mux (
        .idx(idx), .pkt_num(pkt_num), .snap(snap), .word(out_data)
    );

    // Stream qualifiers come straight from the sequencer.
    always_comb begin
        out_valid = busy;
        out_last  = last;
    end
endmodule

// File: rtl/trig_pkt_fmt_chk.sv
// Protocol checker for trig_pkt_fmt, attached by bind.
module trig_pkt_fmt_chk #(
    parameter int unsigned OVF_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_en,
    input logic             accept,
    input logic             out_ready,
    input logic             out_valid,
    input logic             out_last,
    input logic [31:0]      out_data,
    input logic [OVF_W-1:0] drop_cnt
);
    localparam logic [OVF_W-1:0] ONE = {{(OVF_W-1){1'b0}}, 1'b1};

    // R2
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && accept && pkt_en) |=> (out_valid && !out_last));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && !(accept && pkt_en)) |=> !out_valid);

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R11
    end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid);

    // R8
    foot_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_data[31:28] == 4'h9));

    // R12
    drop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && accept && (drop_cnt != '1)) |=> (drop_cnt == $past(drop_cnt) + ONE));

    // R12
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && accept) |=> $stable(drop_cnt));
endmodule

bind trig_pkt_fmt trig_pkt_fmt_chk #(.OVF_W(OVF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pkt_en(pkt_en), .accept(accept),
    .out_ready(out_ready), .out_valid(out_valid), .out_last(out_last),
    .out_data(out_data), .drop_cnt(drop_cnt)
);

// File: tb/tb_trig_pkt_fmt.sv
`timescale 1ns/1ps
module tb_trig_pkt_fmt;
    localparam int OVF_W  = 4;
    localparam int OVF_MX = (1 << OVF_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pkt_en = 1'b0, accept = 1'b0, out_ready = 1'b0;
    logic [31:0] timestamp = '0, cnt_accepted = '0, cnt_input = '0, cnt_pulser = '0;
    logic adc16_or = 0, adc32_or = 0, adc_any_or = 0, ext_or = 0;
    logic coinc_top = 0, coinc_bot = 0, coinc_all = 0;
    logic [15:0] coinc_reg = '0;
    logic [7:0]  mult_cnt = '0;
    logic [31:0] nim_bits = '0, esata_bits = '0;
    logic [31:0] out_data;
    logic out_valid, out_last;
    logic [OVF_W-1:0] drop_cnt;

    always #2.5 clk = ~clk;

    trig_pkt_fmt #(.OVF_W(OVF_W)) dut (.*);

    int errors = 0, checks = 0;
    bit done = 0;

    // Reference model state
    bit          m_busy = 0;
    int          m_idx = 0;
    int unsigned m_pkt = 0;
    int          m_drop = 0;
    logic [31:0] m_words [10];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string word_tag(input int i);
        case (i)
            0: return "R3 word0";
            1: return "R4 header";
            2, 3, 4, 5: return "R5 payload";
            6: return "R6 bitmap";
            7, 8: return "R7 ext bits";
            default: return "R8 footer";
        endcase
    endfunction

    // One cycle: fresh payload, model update, edge, compare.
    task automatic step(input logic acc, input logic rdy);
        @(negedge clk);
        accept = acc; out_ready = rdy;
        timestamp = $urandom; cnt_accepted = $urandom; cnt_input = $urandom;
        cnt_pulser = $urandom;
        {adc16_or, adc32_or, adc_any_or, ext_or, coinc_top, coinc_bot, coinc_all} = 7'($urandom);
        coinc_reg = 16'($urandom); mult_cnt = 8'($urandom);
        nim_bits = $urandom; esata_bits = $urandom;
        if (m_busy) begin
            if (acc && m_drop < OVF_MX) m_drop++;
            if (rdy) begin
                if (m_idx == 9) begin m_busy = 0; m_pkt++; end
                else m_idx++;
            end
        end else if (acc && pkt_en) begin
            m_busy = 1; m_idx = 0;
            m_words[0] = m_pkt;
            m_words[1] = {4'h8, cnt_accepted[27:0]};
            m_words[2] = timestamp;
            m_words[3] = cnt_accepted;
            m_words[4] = cnt_input;
            m_words[5] = cnt_pulser;
            m_words[6] = {mult_cnt, coinc_reg, 1'b0, coinc_all, coinc_bot, coinc_top,
                          ext_or, adc_any_or, adc32_or, adc16_or};
            m_words[7] = nim_bits;
            m_words[8] = esata_bits;
            m_words[9] = {4'h9, cnt_accepted[27:0]};
        end
        @(posedge clk); #1;
        check("R2/R9/R13 valid", 32'(out_valid), 32'(m_busy));
        check("R12 drop_cnt", 32'(drop_cnt), 32'(m_drop));
        if (m_busy) begin
            check(word_tag(m_idx), out_data, m_words[m_idx]);
            check("R11 last", 32'(out_last), 32'(m_idx == 9));
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid", 32'(out_valid), 32'h0);
        check("R1 drop_cnt", 32'(drop_cnt), 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // R2/R3 plain packet with ready high
        pkt_en = 1;
        step(1, 1);
        repeat (12) step(0, 1);
        // R10/R11 packet with random stalls
        step(1, 0);
        repeat (40) step(0, 1'($urandom));
        repeat (12) step(0, 1);
        // R12 accepts during a packet are dropped
        step(1, 1);
        repeat (3) step(1, 1);
        repeat (12) step(0, 1);
        // R9 disabled: accepts ignored
        pkt_en = 0;
        repeat (3) step(1, 1);
        repeat (2) step(0, 1);
        // R13 disable mid-packet
        pkt_en = 1;
        step(1, 1);
        pkt_en = 0;
        repeat (12) step(0, 1);
        // R12 accept on footer handshake is dropped, the next one starts
        pkt_en = 1;
        step(1, 1);
        repeat (9) step(0, 1);
        step(1, 1);
        step(1, 1);
        repeat (12) step(0, 1);
        // R12 saturation while stalled
        step(1, 0);
        repeat (20) step(1, 0);
        repeat (12) step(0, 1);
        // Mixed traffic
        for (int i = 0; i < 400; i++) begin
            pkt_en = ($urandom % 8) != 0;
            step(($urandom % 6) == 0, 1'($urandom));
        end
        pkt_en = 1;
        repeat (40) step(0, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule